// File: doc/BRIEF.md
# Strobe-Framed Serial PCM Port

This block connects a two-lane serial PCM bus to a parallel sample core. Both lanes share one variable-rate bit clock, and each lane has its own active-high enable strobe. The strobe on lane 0 sets the frame. While a lane's strobe is high, one sample enters on the lane's serial input and one sample leaves on its serial output, most significant bit first. A strobe is 8 bit clocks long for 8-bit companded data or 16 bit clocks long for 16-bit two's-complement linear data. The two lanes may use different widths. The block runs on a faster reference clock. It samples the bit clock, the strobes and the serial inputs, and it acts on rising edges of the bit clock.

The block measures the length of every strobe. A strobe of 8 or 16 bit clocks gives a sample, and the first such sample fixes the width of that lane until reset. A strobe of any other length, or a valid length that differs from the fixed width, is reported and its sample is dropped. A timer counts reference clocks from the rising edge of the lane-0 strobe and reports when the lane-1 strobe has not risen within a limit set at a port.

Top module: `spcm_port`

## Requirements
- R1: `frame_pulse` is a one-reference-clock pulse, raised once for each rising edge of `stb[0]`.
- R2: A lane's serial input is sampled on each rising edge of `bit_clk` while its strobe is high. The first bit sampled is the most significant. A 16-clock strobe delivers all 16 bits on `smp_data` with `smp_wide`=1.
- R3: An 8-clock strobe delivers the 8 sampled bits in `smp_data` bits [7:0] of that lane. Bits [15:8] of that lane are 0, and `smp_wide`=0.
- R4: `smp_valid` of a lane pulses for one reference clock, within three reference clocks after that lane's strobe falls. There is at most one pulse per strobe.
- R5: From the lane's `core_tx` word, `ser_out` presents the sample MSB first, and each bit is held until the next rising edge of `bit_clk`. Until the lane's width is fixed, and while it is fixed at 16, the whole 16-bit word is sent. When the width is fixed at 8, bits [7:0] are sent, followed by zeros.
- R6: `ser_oe` of a lane is high while its strobe is high and low otherwise, with two reference clocks of latency. The lane's sample pulse comes only while `ser_oe` is low.
- R7: A strobe whose length is neither 8 nor 16 bit clocks gives a one-clock `len_err` pulse, no sample, and no change to the lane's fixed width.
- R8: After a lane's width is fixed, a valid-length strobe of the other width gives a one-clock `fmt_err` pulse and no sample. The fixed width stays, so a later strobe of the fixed width is accepted again.
- R9: Each lane fixes its width on its own, so lane 0 may carry 16-bit data while lane 1 carries 8-bit data, and the other way round.
- R10: If `stb[1]` has not risen `win_limit` reference clocks after a rising edge of `stb[0]`, `win_timeout` pulses for one clock. If `stb[1]` rises earlier, there is no pulse.
- R11: While reset is asserted and after reset, all pulse outputs, `ser_oe` and `smp_data` are 0, and no lane width is fixed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Serial bit clock, sampled by clk |
| stb | input | 2 | Enable strobes; bit 0 frames the lanes |
| ser_in | input | 2 | Serial data in, one bit per lane |
| ser_out | output | 2 | Serial data out, one bit per lane |
| ser_oe | output | 2 | Output enable per lane; pad is high impedance when low |
| core_tx | input | 2*SMP_W | Parallel samples to send; lane i at bits [i*SMP_W +: SMP_W] |
| win_limit | input | TMR_W | Window limit in reference clocks |
| frame_pulse | output | 1 | Frame start pulse |
| win_timeout | output | 1 | Second strobe missed the window |
| smp_valid | output | 2 | Per-lane received-sample pulse |
| smp_wide | output | 2 | Per-lane width tag, 1 = 16-bit |
| smp_data | output | 2*SMP_W | Per-lane received sample |
| len_err | output | 2 | Per-lane bad strobe length pulse |
| fmt_err | output | 2 | Per-lane width change pulse |

## Verification
The window timer and the lane-0 outcome logic can act in the same reference clock. The timer expires while the lane-0 strobe is still shifting, or right as its fall is judged. The bench sets `win_limit` both below and above the time from the lane-0 rise to the lane-1 rise, for 8-bit and 16-bit framing strobes. It judges the timeout count apart from the sample, error and frame-pulse counts of each lane. A sample pulse and an error pulse from the two lanes never meet, because the strobes are serialised. Their mutual exclusion within one lane is checked on every fall.

// File: rtl/spcm_pkg.sv
package spcm_pkg;

  typedef enum logic [1:0] {
    LEN_BAD    = 2'd0,
    LEN_NARROW = 2'd1,
    LEN_WIDE   = 2'd2
  } len_cls_t;

  // Map a counted strobe length onto a sample class
  function automatic len_cls_t classify_len(input int bits, input int nar, input int wid);
    if (bits == wid) return LEN_WIDE;
    if (bits == nar) return LEN_NARROW;
    return LEN_BAD;
  endfunction

endpackage

// File: rtl/spcm_sync.sv
module spcm_sync #(
  parameter int NP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_clk,
  input  logic [NP-1:0] stb,
  input  logic [NP-1:0] ser_in,
  output logic          tick,
  output logic [NP-1:0] stb_lvl,
  output logic [NP-1:0] stb_rise,
  output logic [NP-1:0] stb_fall,
  output logic [NP-1:0] din
);

  logic          bclk_q, bclk_qq;
  logic [NP-1:0] stb_q, stb_qq, din_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      bclk_qq <= 1'b0;
      stb_q   <= '0;
      stb_qq  <= '0;
      din_q   <= '0;
    end else begin
      bclk_q  <= bit_clk;
      bclk_qq <= bclk_q;
      stb_q   <= stb;
      stb_qq  <= stb_q;
      din_q   <= ser_in;
    end
  end

  assign tick     = bclk_q & ~bclk_qq;
  assign stb_lvl  = stb_q;
  assign stb_rise = stb_q & ~stb_qq;
  assign stb_fall = ~stb_q & stb_qq;
  assign din      = din_q;

endmodule

// File: rtl/spcm_lane.sv
module spcm_lane
  import spcm_pkg::*;
#(
  parameter int SMP_W = 16,
  parameter int NAR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             stb_lvl,
  input  logic             stb_rise,
  input  logic             stb_fall,
  input  logic             din,
  input  logic [SMP_W-1:0] tx_word,
  output logic             ser_out,
  output logic             ser_oe,
  output logic             smp_valid,
  output logic             smp_wide,
  output logic [SMP_W-1:0] smp_data,
  output logic             len_err,
  output logic             fmt_err
);

  localparam int CNT_W = $clog2(SMP_W * 2);
  localparam int PAD_W = SMP_W - NAR_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] bit_cnt;
  logic [SMP_W-1:0] rx_sh, tx_sh;
  logic             locked, lock_wide, oe_q;

  // Serial image of a core word for the current width state
  function automatic logic [SMP_W-1:0] tx_image(input logic [SMP_W-1:0] w, input logic nar);
    tx_image = nar ? {w[NAR_W-1:0], {PAD_W{1'b0}}} : w;
  endfunction

  // Parallel sample from the receive shifter
  function automatic logic [SMP_W-1:0] rx_image(input logic [SMP_W-1:0] sh, input logic wide);
    rx_image = wide ? sh : {{PAD_W{1'b0}}, sh[NAR_W-1:0]};
  endfunction

  len_cls_t cls;
  logic     shift_en, cls_wide, width_clash, accept_evt, reject_len, reject_fmt;

  assign cls         = classify_len(int'(bit_cnt), NAR_W, SMP_W);
  assign shift_en    = tick & stb_lvl & ~stb_rise;
  assign cls_wide    = (cls == LEN_WIDE);
  assign width_clash = locked & (cls_wide != lock_wide);
  assign reject_len  = stb_fall & (cls == LEN_BAD);
  assign reject_fmt  = stb_fall & (cls != LEN_BAD) & width_clash;
  assign accept_evt  = stb_fall & (cls != LEN_BAD) & ~width_clash;

  // Shift datapath and bit counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= stb_lvl;
      if (stb_rise) begin
        bit_cnt <= '0;
        tx_sh   <= tx_image(tx_word, locked & ~lock_wide);
      end else if (shift_en) begin
        rx_sh <= {rx_sh[SMP_W-2:0], din};
        tx_sh <= {tx_sh[SMP_W-2:0], 1'b0};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + CNT_W'(1);
      end
    end
  end

  // Outcome of each strobe and width lock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_wide  <= 1'b0;
      smp_data  <= '0;
      len_err   <= 1'b0;
      fmt_err   <= 1'b0;
      locked    <= 1'b0;
      lock_wide <= 1'b0;
    end else begin
      smp_valid <= accept_evt;
      len_err   <= reject_len;
      fmt_err   <= reject_fmt;
      if (accept_evt) begin
        smp_data  <= rx_image(rx_sh, cls_wide);
        smp_wide  <= cls_wide;
        locked    <= 1'b1;
        lock_wide <= cls_wide;
      end
    end
  end

  assign ser_out = tx_sh[SMP_W-1];
  assign ser_oe  = oe_q;

endmodule

// File: rtl/spcm_window.sv
module spcm_window #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_evt,
  input  logic             close_evt,
  input  logic [TMR_W-1:0] limit,
  output logic             timeout
);

  logic             armed;
  logic [TMR_W-1:0] cnt;
  logic             expire_evt;

  assign expire_evt = armed & ~open_evt & ~close_evt & (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      cnt     <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= expire_evt;
      if (open_evt) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (close_evt || expire_evt) begin
        armed <= 1'b0;
      end else if (armed) begin
        cnt <= cnt + TMR_W'(1);
      end
    end
  end

endmodule

// File: rtl/spcm_port.sv
module spcm_port #(
  parameter int SMP_W = 16,
  parameter int NAR_W = 8,
  parameter int TMR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_clk,
  input  logic [1:0]         stb,
  input  logic [1:0]         ser_in,
  output logic [1:0]         ser_out,
  output logic [1:0]         ser_oe,
  input  logic [2*SMP_W-1:0] core_tx,
  input  logic [TMR_W-1:0]   win_limit,
  output logic               frame_pulse,
  output logic               win_timeout,
  output logic [1:0]         smp_valid,
  output logic [1:0]         smp_wide,
  output logic [2*SMP_W-1:0] smp_data,
  output logic [1:0]         len_err,
  output logic [1:0]         fmt_err
);

  localparam int NP = 2;

  logic          tick;
  logic [NP-1:0] stb_lvl, stb_rise, stb_fall, din;

  spcm_sync #(.NP(NP)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_clk  (bit_clk),
    .stb      (stb),
    .ser_in   (ser_in),
    .tick     (tick),
    .stb_lvl  (stb_lvl),
    .stb_rise (stb_rise),
    .stb_fall (stb_fall),
    .din      (din)
  );

  for (genvar i = 0; i < NP; i++) begin : g_lane
    spcm_lane #(.SMP_W(SMP_W), .NAR_W(NAR_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .stb_lvl   (stb_lvl[i]),
      .stb_rise  (stb_rise[i]),
      .stb_fall  (stb_fall[i]),
      .din       (din[i]),
      .tx_word   (core_tx[i*SMP_W +: SMP_W]),
      .ser_out   (ser_out[i]),
      .ser_oe    (ser_oe[i]),
      .smp_valid (smp_valid[i]),
      .smp_wide  (smp_wide[i]),
      .smp_data  (smp_data[i*SMP_W +: SMP_W]),
      .len_err   (len_err[i]),
      .fmt_err   (fmt_err[i])
    );
  end

  spcm_window #(.TMR_W(TMR_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_evt  (stb_rise[0]),
    .close_evt (stb_rise[1]),
    .limit     (win_limit),
    .timeout   (win_timeout)
  );

  assign frame_pulse = stb_rise[0];

endmodule

// File: rtl/spcm_port_chk.sv
module spcm_port_chk #(
  parameter int SMP_W = 16,
  parameter int NAR_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               stb_fall,
  input logic [1:0]               ser_oe,
  input logic                     frame_pulse,
  input logic                     win_timeout,
  input logic [1:0]               smp_valid,
  input logic [1:0]               smp_wide,
  input logic [SMP_W-NAR_W-1:0]   hi0,
  input logic [SMP_W-NAR_W-1:0]   hi1,
  input logic [1:0]               len_err,
  input logic [1:0]               fmt_err
);

  logic [1:0] seen, last_wide;
  logic [SMP_W-NAR_W-1:0] hi [2];

  assign hi[0] = hi0;
  assign hi[1] = hi1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen      <= '0;
      last_wide <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (smp_valid[i]) begin
          seen[i]      <= 1'b1;
          last_wide[i] <= smp_wide[i];
        end
      end
    end
  end

  // R1
  frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_pulse |=> !frame_pulse);

  // R10
  timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_timeout |=> !win_timeout);

  for (genvar i = 0; i < 2; i++) begin : g_lane_chk
    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid[i] |=> !smp_valid[i]);

    // R4
    valid_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid[i] |-> $past(stb_fall[i]));

    // R6
    valid_oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid[i] |-> !ser_oe[i]);

    // R7
    outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({smp_valid[i], len_err[i], fmt_err[i]}));

    // R3
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid[i] && !smp_wide[i]) |-> (hi[i] == '0));

    // R8
    width_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid[i] && seen[i]) |-> (smp_wide[i] == last_wide[i]));
  end

endmodule

bind spcm_port spcm_port_chk #(.SMP_W(SMP_W), .NAR_W(NAR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stb_fall    (stb_fall),
  .ser_oe      (ser_oe),
  .frame_pulse (frame_pulse),
  .win_timeout (win_timeout),
  .smp_valid   (smp_valid),
  .smp_wide    (smp_wide),
  .hi0         (smp_data[SMP_W-1:NAR_W]),
  .hi1         (smp_data[2*SMP_W-1:SMP_W+NAR_W]),
  .len_err     (len_err),
  .fmt_err     (fmt_err)
);

// File: tb/spcm_port_tb.sv
module spcm_port_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_clk = 1'b0;
  logic [1:0]  stb = '0;
  logic [1:0]  ser_in = '0;
  logic [1:0]  ser_out, ser_oe;
  logic [31:0] core_tx = '0;
  logic [15:0] win_limit = 16'd1000;
  logic        frame_pulse, win_timeout;
  logic [1:0]  smp_valid, smp_wide, len_err, fmt_err;
  logic [31:0] smp_data;

  int n_chk = 0, n_fail = 0;
  int vcnt [2], lcnt [2], fcnt [2];
  int tcnt = 0, fpcnt = 0;
  logic [15:0] vdata [2];
  logic        vwide [2];
  bit m_lock [2], m_wide [2];
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  spcm_port u_dut (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .stb(stb), .ser_in(ser_in),
    .ser_out(ser_out), .ser_oe(ser_oe), .core_tx(core_tx), .win_limit(win_limit),
    .frame_pulse(frame_pulse), .win_timeout(win_timeout), .smp_valid(smp_valid),
    .smp_wide(smp_wide), .smp_data(smp_data), .len_err(len_err), .fmt_err(fmt_err)
  );

  initial begin
    for (int p = 0; p < 2; p++) begin
      vcnt[p] = 0; lcnt[p] = 0; fcnt[p] = 0; vdata[p] = '0; vwide[p] = 1'b0;
    end
  end

  always @(negedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (smp_valid[p]) begin
        vcnt[p]++;
        vdata[p] = smp_data[p*16 +: 16];
        vwide[p] = smp_wide[p];
      end
      if (len_err[p]) lcnt[p]++;
      if (fmt_err[p]) fcnt[p]++;
    end
    if (win_timeout) tcnt++;
    if (frame_pulse) fpcnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] tx_expect_img(input logic [15:0] w, input bit lk, input bit wd);
    return (lk && !wd) ? {w[7:0], 8'h00} : w;
  endfunction

  function automatic logic [15:0] rx_expect(input logic [15:0] v, input int len);
    return (len == 16) ? v : {8'h00, v[7:0]};
  endfunction

  // One strobe on lane p: len bit clocks, serial value rxv, core word txw
  task automatic send(input int p, input int len, input logic [15:0] rxv, input logic [15:0] txw);
    int v0, l0, f0;
    logic [15:0] img;
    bit expw;
    v0 = vcnt[p]; l0 = lcnt[p]; f0 = fcnt[p];
    core_tx[p*16 +: 16] = txw;
    img = tx_expect_img(txw, m_lock[p], m_wide[p]);
    for (int i = 0; i < len; i++) begin
      stb[p] = 1'b1;
      ser_in[p] = rxv[len-1-i];
      repeat (3) @(negedge clk);
      chk(ser_oe[p] == 1'b1, "R6", "oe during strobe", ser_oe[p], 1);
      chk(ser_out[p] == ((i < 16) ? img[15-i] : 1'b0), "R5", "serial out bit",
          ser_out[p], (i < 16) ? img[15-i] : 1'b0);
      @(negedge clk); bit_clk = 1'b1;
      repeat (4) @(negedge clk); bit_clk = 1'b0;
    end
    stb[p] = 1'b0;
    ser_in[p] = 1'b0;
    repeat (6) @(negedge clk);
    chk(ser_oe[p] == 1'b0, "R6", "oe after strobe", ser_oe[p], 0);
    expw = (len == 16);
    if (len != 8 && len != 16) begin
      chk(lcnt[p] == l0 + 1, "R7", "len_err count", lcnt[p] - l0, 1);
      chk(vcnt[p] == v0, "R7", "no sample on bad length", vcnt[p] - v0, 0);
    end else if (m_lock[p] && (m_wide[p] != expw)) begin
      chk(fcnt[p] == f0 + 1, "R8", "fmt_err count", fcnt[p] - f0, 1);
      chk(vcnt[p] == v0, "R8", "no sample on width change", vcnt[p] - v0, 0);
    end else begin
      chk(vcnt[p] == v0 + 1, "R4", "one sample pulse", vcnt[p] - v0, 1);
      chk(vdata[p] == rx_expect(rxv, len), expw ? "R2" : "R3", "sample data",
          vdata[p], rx_expect(rxv, len));
      chk(vwide[p] == expw, expw ? "R2" : "R3", "width tag", vwide[p], expw);
      m_lock[p] = 1; m_wide[p] = expw;
    end
  endtask

  task automatic frame(input int l0, input int l1, input bit exp_to);
    int t0, fp0;
    t0 = tcnt; fp0 = fpcnt;
    send(0, l0, 16'($urandom), 16'($urandom));
    send(1, l1, 16'($urandom), 16'($urandom));
    chk(fpcnt == fp0 + 1, "R1", "frame pulse count", fpcnt - fp0, 1);
    chk(tcnt == t0 + (exp_to ? 1 : 0), "R10", "timeout count", tcnt - t0, exp_to ? 1 : 0);
  endtask

  function automatic int pick_len(input int p);
    int r;
    int bad [4] = '{5, 12, 15, 3};
    r = $urandom_range(0, 9);
    if (r == 9) return bad[$urandom_range(0, 3)];
    if (!m_lock[p]) return (p == 0) ? 16 : 8;
    if (r == 8) return m_wide[p] ? 8 : 16;
    return m_wide[p] ? 16 : 8;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    stb = '0; ser_in = '0; bit_clk = 1'b0;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk(smp_valid == 2'b00 && len_err == 2'b00 && fmt_err == 2'b00, "R11", "pulses in reset",
        {smp_valid, len_err, fmt_err}, 0);
    chk(ser_oe == 2'b00 && win_timeout == 1'b0 && frame_pulse == 1'b0, "R11", "oe/timeout in reset",
        {ser_oe, win_timeout, frame_pulse}, 0);
    chk(smp_data == 32'h0, "R11", "data in reset", smp_data, 0);
    rst_n = 1'b1;
    for (int p = 0; p < 2; p++) begin m_lock[p] = 0; m_wide[p] = 0; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R7 bad first strobe leaves lane unlocked, then R9 mixed widths
    send(0, 12, 16'h0abc, 16'h1234);
    frame(16, 8, 0);
    // R8 width change on a narrow lane, then kept width accepted
    send(1, 16, 16'hbeef, 16'hcafe);
    send(1, 8, 16'h00a5, 16'h005a);
    // constrained random frames
    for (int k = 0; k < 30; k++) frame(pick_len(0), pick_len(1), 0);
    // R9 swapped widths after reset
    do_reset();
    frame(8, 16, 0);
    for (int k = 0; k < 8; k++) frame(pick_len(0), pick_len(1), 0);
    // R10 window: expiry during lane-0 strobe, near its end, and in time
    win_limit = 16'd40;
    frame(8, 8, 1);
    win_limit = 16'd66;
    frame(8, 16, 1);
    win_limit = 16'd300;
    frame(16, 8, 0);
    win_limit = 16'd40;
    begin
      int t0;
      t0 = tcnt;
      send(0, 16, 16'h8001, 16'h7ffe);
      repeat (20) @(negedge clk);
      chk(tcnt == t0 + 1, "R10", "timeout without second strobe", tcnt - t0, 1);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule